// File: doc/BRIEF.md
# Level-Interrupt Router onto Sixteen ISA Lines

This block collects level-sensitive interrupt requests from a set of internal bridge functions and from four external PCI interrupt pins, and drives each of sixteen ISA IRQ lines. Each ISA line is the OR of the sources currently routed to it. Each internal function has its own 8-bit interrupt-line value that selects its target line. Each external pin takes a 4-bit routing nibble from one of three configuration bytes.

Every ISA line keeps a bitmask of the sources that asserted it. A separate global mask records the live level of every source, whether or not that source has a usable route. A source can be remapped while it is asserted. Its old bit is then removed from a line's mask the next time any source event targets that line, because the mask is intersected with the global mask. Routes of 0 or 0xFF switch a source off. A route of 2, or a route above the source's highest allowed line, is rejected. In both cases only the global mask changes.

Level changes are found by comparing the request inputs with the global mask. The router handles one change per clock, and the lowest source bit position goes first. The outputs are registered.

Top module: `irq_router`

## Requirements
- R1: External pin A is routed by bits [7:4] of `pin_rt0`, pin B by bits [3:0] of `pin_rt1`, pin C by bits [7:4] of `pin_rt1`, and pin D by bits [7:4] of `pin_rt2`. The pins occupy source bit positions 8, 9, 10 and 11.
- R2: Internal function f (0 to 7) is routed by byte `fn_line[8f+7:8f]` and occupies source bit position f. A usable route r drives `isa_irq[r]` high while the source is high.
- R3: A route value of 0x00 or 0xFF disables the source. No ISA line rises because of it.
- R4: A route value of 2 is rejected. Values above 15 are rejected, and for functions 2, 3 and 5 values above 14 are rejected. A rejected route raises no line.
- R5: An ISA line is high while at least one source recorded in its mask is still asserted. When several sources share a line, the line falls only after the last of them is released.
- R6: Each source's level is recorded in a global mask even when its route is disabled or rejected. After a line's mask bit is updated, the mask is ANDed with the global mask. A source released after a remap, or while disabled, therefore stops holding its old line at the next event that targets that line.
- R7: One source change is handled per clock edge, and the lowest source bit position is taken first. The ISA outputs are registered and change on the edge that handles the source. At most one ISA line changes per cycle.
- R8: Synchronous active-high reset clears all masks and drives every ISA line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fn_req | input | NUM_FN (8) | Level requests of the internal functions |
| fn_line | input | 8*NUM_FN (64) | Per-function interrupt-line byte, function f in bits [8f+7:8f] |
| pin_req | input | 4 | Levels of external PCI pins A..D |
| pin_rt0 | input | 8 | Routing byte; upper nibble routes pin A |
| pin_rt1 | input | 8 | Routing byte; lower nibble routes pin B, upper nibble routes pin C |
| pin_rt2 | input | 8 | Routing byte; upper nibble routes pin D |
| isa_irq | output | NUM_IRQ (16) | Registered ISA IRQ levels |

## Verification
The assertions check on every cycle that:
- reset leaves every line low;
- lines 0 and 2 never rise;
- no more than one line changes in one cycle;
- a line rises only when some request was high on the edge before.

The mapping of each nibble and byte to its line, the per-function ceiling of 14, the OR of several sources on one line, the removal of stale bits after a remap or a disable, and the order in which simultaneous changes are handled are shown only by the bench's scenarios. The bench compares these against an arithmetic model of the masks.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
  typedef logic [7:0] route_t;

  // A route is usable unless it is a disable code, the reserved cascade
  // line, or above the ceiling allowed for the source.
  function automatic logic route_usable(route_t r, route_t ceiling);
    return !(r == 8'h00 || r == 8'hFF || r == 8'h02 || r > ceiling);
  endfunction
endpackage

// File: rtl/irq_rt_pick.sv
module irq_rt_pick #(
  parameter int N  = 12,
  parameter int IW = 4
) (
  input  logic [N-1:0]  pend,
  output logic          found,
  output logic [IW-1:0] idx
);
  // Lowest set bit wins: scan from the top so the last hit is the lowest.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_rt_decode.sv
module irq_rt_decode
  import irq_rt_pkg::*;
#(
  parameter int          NUM_FN      = 8,
  parameter int          NUM_IRQ     = 16,
  parameter int          IW          = 4,
  parameter int          IRQ_W       = 4,
  parameter logic [31:0] LOWMAX_MASK = 32'h0000_002C
) (
  input  logic [IW-1:0]       idx,
  input  logic [NUM_FN*8-1:0] fn_line,
  input  logic [7:0]          pin_rt0,
  input  logic [7:0]          pin_rt1,
  input  logic [7:0]          pin_rt2,
  output logic [IRQ_W-1:0]    tgt,
  output logic                tgt_ok
);
  localparam int     SLOTS    = 1 << IW;
  localparam int     PIN_BASE = NUM_FN;
  localparam route_t TOP_LINE = route_t'(NUM_IRQ - 1);
  localparam route_t LOW_LINE = route_t'(NUM_IRQ - 2);

  route_t src_route [SLOTS];
  route_t src_ceil  [SLOTS];

  genvar f;
  generate
    for (f = 0; f < NUM_FN; f++) begin : g_fn
      assign src_route[f] = fn_line[f*8 +: 8];
      assign src_ceil[f]  = LOWMAX_MASK[f] ? LOW_LINE : TOP_LINE;
    end
    for (f = PIN_BASE + 4; f < SLOTS; f++) begin : g_spare
      assign src_route[f] = 8'h00;
      assign src_ceil[f]  = 8'h00;
    end
  endgenerate

  // External pins: nibble selection is fixed by the configuration layout.
  assign src_route[PIN_BASE + 0] = {4'h0, pin_rt0[7:4]};
  assign src_route[PIN_BASE + 1] = {4'h0, pin_rt1[3:0]};
  assign src_route[PIN_BASE + 2] = {4'h0, pin_rt1[7:4]};
  assign src_route[PIN_BASE + 3] = {4'h0, pin_rt2[7:4]};
  assign src_ceil[PIN_BASE + 0]  = TOP_LINE;
  assign src_ceil[PIN_BASE + 1]  = TOP_LINE;
  assign src_ceil[PIN_BASE + 2]  = TOP_LINE;
  assign src_ceil[PIN_BASE + 3]  = TOP_LINE;

  logic unused_nibbles;
  assign unused_nibbles = ^{pin_rt0[3:0], pin_rt2[3:0]};

  route_t sel;
  assign sel    = src_route[idx];
  assign tgt_ok = route_usable(sel, src_ceil[idx]);
  assign tgt    = sel[IRQ_W-1:0];

  logic unused_high;
  assign unused_high = ^sel[7:IRQ_W];
endmodule

// File: rtl/irq_rt_bank.sv
module irq_rt_bank #(
  parameter int SRC_W   = 12,
  parameter int NUM_IRQ = 16,
  parameter int IW      = 4,
  parameter int IRQ_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ev,
  input  logic [IW-1:0]      idx,
  input  logic               lvl,
  input  logic [IRQ_W-1:0]   tgt,
  input  logic               tgt_ok,
  output logic [SRC_W-1:0]   glob,
  output logic [NUM_IRQ-1:0] irq_q
);
  logic [SRC_W-1:0] src_bit;
  logic [SRC_W-1:0] glob_nx;

  assign src_bit = SRC_W'(1) << idx;

  always_comb begin
    glob_nx = glob;
    if (ev) glob_nx = lvl ? (glob | src_bit) : (glob & ~src_bit);
  end

  always_ff @(posedge clk) begin
    if (rst) glob <= '0;
    else     glob <= glob_nx;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_IRQ; g++) begin : g_line
      logic [SRC_W-1:0] m_q;
      logic [SRC_W-1:0] m_nx;
      logic             hit;
      logic             line_q;

      assign hit = ev && tgt_ok && (tgt == IRQ_W'(g));

      always_comb begin
        m_nx = m_q;
        if (hit) m_nx = (lvl ? (m_q | src_bit) : (m_q & ~src_bit)) & glob_nx;
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          m_q    <= '0;
          line_q <= 1'b0;
        end else begin
          m_q    <= m_nx;
          line_q <= |m_nx;
        end
      end

      assign irq_q[g] = line_q;
    end
  endgenerate
endmodule

// File: rtl/irq_router.sv
module irq_router #(
  parameter int          NUM_FN      = 8,
  parameter int          NUM_IRQ     = 16,
  parameter logic [31:0] LOWMAX_MASK = 32'h0000_002C
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_FN-1:0]   fn_req,
  input  logic [NUM_FN*8-1:0] fn_line,
  input  logic [3:0]          pin_req,
  input  logic [7:0]          pin_rt0,
  input  logic [7:0]          pin_rt1,
  input  logic [7:0]          pin_rt2,
  output logic [NUM_IRQ-1:0]  isa_irq
);
  localparam int SRC_W = NUM_FN + 4;
  localparam int IW    = $clog2(SRC_W);
  localparam int IRQ_W = $clog2(NUM_IRQ);

  logic [SRC_W-1:0] req_all;
  logic [SRC_W-1:0] glob;
  logic [SRC_W-1:0] pend;
  logic             ev;
  logic [IW-1:0]    idx;
  logic             lvl;
  logic [IRQ_W-1:0] tgt;
  logic             tgt_ok;

  assign req_all = {pin_req, fn_req};
  assign pend    = req_all ^ glob;
  assign lvl     = |(req_all & (SRC_W'(1) << idx));

  irq_rt_pick #(.N(SRC_W), .IW(IW)) u_pick (
    .pend  (pend),
    .found (ev),
    .idx   (idx)
  );

  irq_rt_decode #(
    .NUM_FN(NUM_FN), .NUM_IRQ(NUM_IRQ), .IW(IW), .IRQ_W(IRQ_W),
    .LOWMAX_MASK(LOWMAX_MASK)
  ) u_dec (
    .idx     (idx),
    .fn_line (fn_line),
    .pin_rt0 (pin_rt0),
    .pin_rt1 (pin_rt1),
    .pin_rt2 (pin_rt2),
    .tgt     (tgt),
    .tgt_ok  (tgt_ok)
  );

  irq_rt_bank #(.SRC_W(SRC_W), .NUM_IRQ(NUM_IRQ), .IW(IW), .IRQ_W(IRQ_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .ev     (ev),
    .idx    (idx),
    .lvl    (lvl),
    .tgt    (tgt),
    .tgt_ok (tgt_ok),
    .glob   (glob),
    .irq_q  (isa_irq)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_FN  = 8,
  parameter int NUM_IRQ = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_FN-1:0]  fn_req,
  input logic [3:0]         pin_req,
  input logic [NUM_IRQ-1:0] isa_irq
);
  AST_RESET_LINES_LOW: assert property (@(posedge clk)
    rst |=> (isa_irq == '0)); // R8

  AST_LINE0_QUIET: assert property (@(posedge clk) disable iff (rst)
    !isa_irq[0]); // R3

  AST_LINE2_QUIET: assert property (@(posedge clk) disable iff (rst)
    !isa_irq[2]); // R4

  AST_SINGLE_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
    $countones(isa_irq ^ $past(isa_irq)) <= 1); // R7

  AST_RISE_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (rst)
    (|(isa_irq & ~$past(isa_irq))) |-> (|$past({pin_req, fn_req}))); // R5
endmodule

bind irq_router irq_router_chk #(.NUM_FN(NUM_FN), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .fn_req  (fn_req),
  .pin_req (pin_req),
  .isa_irq (isa_irq)
);

// File: tb/tb_irq_router.sv
module tb_irq_router;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  fn_req = '0;
  logic [63:0] fn_line = '0;
  logic [3:0]  pin_req = '0;
  logic [7:0]  pin_rt0 = 8'h77;
  logic [7:0]  pin_rt1 = 8'h77;
  logic [7:0]  pin_rt2 = 8'h77;
  logic [15:0] isa_irq;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;

  logic [11:0] mg;
  logic [11:0] mm [16];

  always #10 clk = ~clk;

  irq_router dut (
    .clk(clk), .rst(rst), .fn_req(fn_req), .fn_line(fn_line),
    .pin_req(pin_req), .pin_rt0(pin_rt0), .pin_rt1(pin_rt1),
    .pin_rt2(pin_rt2), .isa_irq(isa_irq)
  );

  function automatic int route_of(int s);
    case (s)
      8:       return int'(pin_rt0[7:4]);
      9:       return int'(pin_rt1[3:0]);
      10:      return int'(pin_rt1[7:4]);
      11:      return int'(pin_rt2[7:4]);
      default: return int'(fn_line[s*8 +: 8]);
    endcase
  endfunction

  function automatic bit usable(int s, int r);
    int top;
    if (r == 0 || r == 255 || r == 2) return 0;
    top = (s == 2 || s == 3 || s == 5) ? 14 : 15;
    return r <= top;
  endfunction

  function automatic logic [15:0] model_out();
    logic [15:0] e;
    for (int i = 0; i < 16; i++) e[i] = (mm[i] != 0);
    return e;
  endfunction

  // Process every changed source in ascending bit order.
  task automatic model_step();
    logic [11:0] req;
    req = {pin_req, fn_req};
    for (int s = 0; s < 12; s++) begin
      if (req[s] != mg[s]) begin
        int r;
        mg[s] = req[s];
        r = route_of(s);
        if (usable(s, r)) begin
          mm[r][s] = req[s];
          mm[r] = mm[r] & mg;
        end
      end
    end
  endtask

  task automatic model_reset();
    mg = '0;
    for (int i = 0; i < 16; i++) mm[i] = '0;
  endtask

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic settle();
    repeat (20) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_req(int s, logic v);
    if (s < 8) fn_req[s] = v;
    else       pin_req[s-8] = v;
  endtask

  task automatic set_route(int s, int r);
    case (s)
      8:       pin_rt0[7:4] = 4'(r);
      9:       pin_rt1[3:0] = 4'(r);
      10:      pin_rt1[7:4] = 4'(r);
      11:      pin_rt2[7:4] = 4'(r);
      default: fn_line[s*8 +: 8] = 8'(r);
    endcase
  endtask

  task automatic step_check(string tag);
    model_step();
    settle();
    check(tag, isa_irq, model_out());
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset state", isa_irq, 16'h0000);
    rst = 1'b0;
    settle();
    check("R8 idle after reset", isa_irq, 16'h0000);

    // Sweep of every source over its route values (R1 R2 R3 R4).
    for (int s = 0; s < 12; s++) begin
      int nr;
      nr = (s < 8) ? 18 : 16;
      for (int k = 0; k < nr; k++) begin
        int r;
        string tag;
        r = (k < 16) ? k : ((k == 16) ? 16 : 255);
        if (r == 0 || r == 255)   tag = "R3 disabled route";
        else if (!usable(s, r))   tag = "R4 rejected route";
        else if (s >= 8)          tag = "R1 pin nibble route";
        else                      tag = "R2 function line route";
        fn_line = '0;
        pin_rt0 = 8'h77; pin_rt1 = 8'h77; pin_rt2 = 8'h77;
        set_route(s, r);
        set_req(s, 1'b1);
        step_check($sformatf("%s src %0d route %0d raise", tag, s, r));
        set_req(s, 1'b0);
        step_check($sformatf("%s src %0d route %0d drop", tag, s, r));
      end
    end

    // R7: two simultaneous changes, lower bit position first.
    fn_line = '0;
    set_route(1, 9);
    set_route(8, 10);
    fn_req[1]  = 1'b1;
    pin_req[0] = 1'b1;
    #1 check("R7 registered output before edge", isa_irq, 16'h0000);
    @(posedge clk); @(negedge clk);
    check("R7 first edge handles function 1", isa_irq, 16'h0200);
    @(posedge clk); @(negedge clk);
    check("R7 second edge handles pin A", isa_irq, 16'h0600);
    model_step();
    fn_req[1] = 1'b0; pin_req[0] = 1'b0;
    step_check("R7 both released");

    // R5: two sources share one line.
    set_route(4, 7); set_route(6, 7);
    fn_req[4] = 1'b1; fn_req[6] = 1'b1;
    step_check("R5 shared line high");
    fn_req[4] = 1'b0;
    step_check("R5 shared line held by second source");
    check("R5 line 7 still high", isa_irq, 16'h0080);
    fn_req[6] = 1'b0;
    step_check("R5 shared line low after last release");

    // R6: remap while asserted leaves a stale bit until pruned.
    set_route(4, 5);
    fn_req[4] = 1'b1;
    step_check("R6 source on line 5");
    set_route(4, 6);
    step_check("R6 remap alone changes nothing");
    fn_req[4] = 1'b0;
    step_check("R6 stale bit holds line 5");
    check("R6 line 5 stale high", isa_irq, 16'h0020);
    set_route(0, 5);
    fn_req[0] = 1'b1;
    step_check("R6 new source on line 5");
    fn_req[0] = 1'b0;
    step_check("R6 line 5 pruned");
    check("R6 line 5 low after prune", isa_irq, 16'h0000);

    // R6: release while disabled still clears the global level.
    set_route(11, 3);
    pin_req[3] = 1'b1;
    step_check("R6 pin D on line 3");
    set_route(11, 0);
    pin_req[3] = 1'b0;
    step_check("R6 release while disabled");
    set_route(1, 3);
    fn_req[1] = 1'b1;
    step_check("R6 other source on line 3");
    fn_req[1] = 1'b0;
    step_check("R6 line 3 pruned of disabled source");
    check("R6 line 3 low", isa_irq, 16'h0000);

    // R8: reset in mid-operation.
    set_route(3, 4);
    fn_req[3] = 1'b1;
    step_check("R8 line 4 before reset");
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8 reset clears lines", isa_irq, 16'h0000);
    fn_req = '0;
    model_reset();
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    settle();
    check("R8 quiet after reset release", isa_irq, 16'h0000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R7 run did not finish got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule